// File: doc/BRIEF.md
# Gated Divided Clock Pin Driver

This block drives one general-purpose pin that can either carry ordinary output data or, as an alternate function, a clock derived from the reference clock. In clock mode an 8-bit divider value picks the frequency. A value of 0 passes the reference straight through. A value N from 1 to 255 gives a square wave whose high and low halves each last N reference cycles, so the pin runs at the reference frequency divided by 2N.

The clock reaches the pin only while two conditions hold: the host has finished configuring the device, and the device is not suspended. Whenever the clock is gated off, the pin is held low. The gating never cuts a pulse short. A high half that is already in progress runs to its full length, and only then does the pin fall and stay low.

When the alternate function is not selected, the pin falls back to plain GPIO behaviour, using registered output data and a registered output enable. After reset the pin is an undriven input, and software must select a mode again before the pin is driven.

Top module: `clkout_pin_gen`

## Requirements
- R1: During and after reset, `pin_oe_o` is 0 and `pin_o` is 0. The pin stays an input until `alt_en_i` or `gpio_oe_i` has been sampled high at a clock edge.
- R2: With `alt_en_i`=0, the pin mode is registered on the next edge. With `gpio_oe_i`=1 this gives `pin_oe_o`=1 and `pin_o` equal to `gpio_out_i` sampled at that edge. With `gpio_oe_i`=0 it gives `pin_oe_o`=0.
- R3: With `alt_en_i`=1 and `configured_i`=0, `pin_oe_o` is 1 and `pin_o` stays low.
- R4: With `alt_en_i`=1 and `suspend_i`=1, `pin_o` stays low, for every divider value including 0.
- R5: With the clock enabled and a divider value N from 1 to 255, every high half and every low half of `pin_o` lasts exactly N reference cycles.
- R6: With the clock enabled and a divider value of 0, `pin_o` follows the reference clock: it is high in the high phase and low in the low phase.
- R7: A change of `div_i` takes effect at the next half-period boundary. The half that is in progress keeps its old length, and the following half uses the new value.
- R8: When the clock is gated off during a high half, that half still lasts N cycles. The pin then stays low with no further pulse until the clock is enabled again.
- R9: When the clock is enabled from an idle state, the output begins with a full low half of N cycles before its first rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | Clock divider value; 0 selects pass-through |
| alt_en_i | input | 1 | Selects the clock alternate function for the pin |
| configured_i | input | 1 | High once device configuration is complete |
| suspend_i | input | 1 | High while the device is suspended |
| gpio_out_i | input | 1 | GPIO output data |
| gpio_oe_i | input | 1 | GPIO output enable |
| pin_o | output | 1 | Pin drive value |
| pin_oe_o | output | 1 | Pin output enable |

## Verification
A corrupted half-period counter or a stale divider value shows up on the pin within one half period. It appears as a high or low run that is not N samples long, or as a run that uses the new N one half too early or too late. A stop state that is wrong appears at once as a shortened final high pulse or a stray pulse while the pin is gated. Both are measured by counting runs of samples. A faulty mode register shows up one cycle after the mode inputs change, as a wrong output enable or wrong data.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
  typedef enum logic [1:0] {
    PIN_IN  = 2'd0,
    PIN_OUT = 2'd1,
    PIN_CLK = 2'd2
  } pin_mode_e;

  localparam int unsigned DIV_W_DEF = 8;
endpackage

// File: rtl/clkout_mode_reg.sv
module clkout_mode_reg
  import clkout_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      alt_en_i,
  input  logic      gpio_oe_i,
  input  logic      gpio_out_i,
  output pin_mode_e mode_o,
  output logic      dout_o
);
  pin_mode_e mode_q;
  logic      dout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= PIN_IN;
      dout_q <= 1'b0;
    end else begin
      if (alt_en_i)       mode_q <= PIN_CLK;
      else if (gpio_oe_i) mode_q <= PIN_OUT;
      else                mode_q <= PIN_IN;
      dout_q <= gpio_out_i;
    end
  end

  assign mode_o = mode_q;
  assign dout_o = dout_q;
endmodule

// File: rtl/clkout_divider.sv
module clkout_divider #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             div_clk_o,
  output logic             bypass_o
);
  logic [DIV_W-1:0] n_q, cnt_q, n_last;
  logic             run_q, div_q, n_zero, tick;

  assign n_zero = (n_q == '0);
  assign n_last = n_q - 1'b1;
  assign tick   = !n_zero && (cnt_q == n_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      div_q <= 1'b0;
      cnt_q <= '0;
      n_q   <= '0;
    end else if (!run_q || n_zero) begin
      // idle or pass-through: reload every cycle, stop at once
      run_q <= en_i;
      div_q <= 1'b0;
      cnt_q <= '0;
      n_q   <= div_i;
    end else if (!en_i && !div_q) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
      n_q   <= div_i;
      div_q <= (div_i == '0) ? 1'b0 : !div_q;
      if (!en_i) run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign div_clk_o = div_q;
  assign bypass_o  = run_q && n_zero;

  // R3 R4: a rising edge only follows an enabled cycle
  assert_rise_enabled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div_q) |-> $past(en_i));
  // R8: the divider always stops at low level
  assert_stop_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_q) |-> !div_q);
  // R5: output moves only on a half-period boundary
  assert_toggle_boundary_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !n_zero && !tick) |=> $stable(div_q));
endmodule

// File: rtl/clkout_bypass_gate.sv
module clkout_bypass_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic clk_o
);
  logic en_n;

  // enable captured in the low phase so the AND cannot chop a high phase
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_n <= 1'b0;
    else         en_n <= en_i;
  end

  assign clk_o = clk_i & en_n;
endmodule

// File: rtl/clkout_pin_gen.sv
module clkout_pin_gen
  import clkout_pkg::*;
#(
  parameter int unsigned DIV_W = DIV_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             alt_en_i,
  input  logic             configured_i,
  input  logic             suspend_i,
  input  logic             gpio_out_i,
  input  logic             gpio_oe_i,
  output logic             pin_o,
  output logic             pin_oe_o
);
  pin_mode_e mode;
  logic      dout, clk_en, div_clk, bypass, byp_clk;
  logic      started_q;

  clkout_mode_reg u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .alt_en_i   (alt_en_i),
    .gpio_oe_i  (gpio_oe_i),
    .gpio_out_i (gpio_out_i),
    .mode_o     (mode),
    .dout_o     (dout)
  );

  assign clk_en = (mode == PIN_CLK) && configured_i && !suspend_i;

  clkout_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (clk_en),
    .div_i     (div_i),
    .div_clk_o (div_clk),
    .bypass_o  (bypass)
  );

  clkout_bypass_gate u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (bypass),
    .clk_o  (byp_clk)
  );

  always_comb begin
    unique case (mode)
      PIN_CLK: pin_o = div_clk | byp_clk;
      PIN_OUT: pin_o = dout;
      default: pin_o = 1'b0;
    endcase
  end

  assign pin_oe_o = (mode != PIN_IN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started_q <= 1'b0;
    else         started_q <= 1'b1;
  end

  // R1: input mode requested means the pin is not driven
  assert_input_undriven_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && $past(!alt_en_i && !gpio_oe_i)) |-> !pin_oe_o);
  // R2: GPIO output mode drives last cycle's data
  assert_gpio_data_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && $past(gpio_oe_i && !alt_en_i)) |-> (pin_oe_o && pin_o == $past(gpio_out_i)));
endmodule

// File: tb/tb_clkout_pin_gen.sv
module tb_clkout_pin_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div = 8'd0;
  logic       alt_en = 1'b0, cfg = 1'b0, susp = 1'b0, gout = 1'b0, goe = 1'b0;
  logic       pin, pin_oe;
  int         n_chk = 0, n_fail = 0, cyc = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  clkout_pin_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div), .alt_en_i(alt_en),
    .configured_i(cfg), .suspend_i(susp), .gpio_out_i(gout), .gpio_oe_i(goe),
    .pin_o(pin), .pin_oe_o(pin_oe)
  );

  function automatic int exp_half(input int n);
    return n;  // each half lasts n reference cycles
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_rise(output bit found);
    logic prev;
    prev  = pin;
    found = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!prev && pin) begin found = 1'b1; break; end
      prev = pin;
    end
  endtask

  task automatic run_len(input logic lvl, output int n);
    n = 1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (pin !== lvl) break;
      n++;
    end
  endtask

  task automatic measure(input int n, input string req);
    bit f; int h, l;
    wait_rise(f);
    check(f, req, f, 1);
    run_len(1'b1, h);
    check(h == exp_half(n), req, h, exp_half(n));
    run_len(1'b0, l);
    check(l == exp_half(n), req, l, exp_half(n));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int r, n, a, b, l, hi_ok;
    bit f;
    r = $urandom(32'd2718);
    repeat (3) @(negedge clk);
    check(pin_oe == 1'b0 && pin == 1'b0, "R1 reset", {pin_oe, pin}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(pin_oe == 1'b0, "R1 input default", pin_oe, 0);

    // R2 GPIO output with random data
    goe = 1'b1;
    for (int i = 0; i < 8; i++) begin
      gout = 1'($urandom);
      @(negedge clk);
      check(pin_oe == 1'b1 && pin == gout, "R2 gpio data", {pin_oe, pin}, {1'b1, gout});
    end
    goe = 1'b0;
    @(negedge clk);
    check(pin_oe == 1'b0, "R2 gpio input", pin_oe, 0);

    // R3 not configured
    div = 8'd3; alt_en = 1'b1; cfg = 1'b0;
    hi_ok = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pin !== 1'b0 || pin_oe !== 1'b1) hi_ok = 0;
    end
    check(hi_ok == 1, "R3 unconfigured low", hi_ok, 1);

    // R4 suspended
    cfg = 1'b1; susp = 1'b1;
    hi_ok = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pin !== 1'b0) hi_ok = 0;
    end
    check(hi_ok == 1, "R4 suspended low", hi_ok, 1);

    // R9 first half after enable is a full low half
    div = 8'd5; susp = 1'b0;
    l = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pin) break;
      l++;
    end
    check(l >= 5 && l <= 7, "R9 leading low half", l, 6);

    // R5 directed and random dividers
    div = 8'd1;   measure(1, "R5 div1");
    div = 8'd1;   measure(1, "R5 div1 steady");
    div = 8'd255; measure(255, "R5 div255");
    div = 8'd255; measure(255, "R5 div255 steady");
    for (int i = 0; i < 6; i++) begin
      n = 1 + int'($urandom % 20);
      div = 8'(n);
      measure(n, "R5 random");
      measure(n, "R5 random steady");
    end

    // R7 change mid-half
    for (int i = 0; i < 3; i++) begin
      a = 2 + int'($urandom % 10);
      b = 2 + int'($urandom % 10);
      div = 8'(a);
      measure(a, "R7 settle");
      wait_rise(f);
      div = 8'(b);
      run_len(1'b1, n);
      check(n == a, "R7 current half keeps old", n, a);
      run_len(1'b0, n);
      check(n == b, "R7 next half uses new", n, b);
    end

    // R8 gate during high half
    for (int i = 0; i < 3; i++) begin
      n = 2 + int'($urandom % 10);
      div = 8'(n);
      measure(n, "R8 settle");
      wait_rise(f);
      susp = 1'b1;
      run_len(1'b1, l);
      check(l == n, "R8 high half completes", l, n);
      hi_ok = 1;
      for (int k = 0; k < 3 * n + 5; k++) begin
        @(negedge clk);
        if (pin !== 1'b0) hi_ok = 0;
      end
      check(hi_ok == 1, "R8 static low", hi_ok, 1);
      susp = 1'b0;
    end

    // R6 pass-through
    div = 8'd0;
    repeat (40) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #2;
      check(pin == 1'b1, "R6 high phase", pin, 1);
      @(negedge clk); #2;
      check(pin == 1'b0, "R6 low phase", pin, 0);
    end
    susp = 1'b1;
    repeat (4) @(negedge clk);
    hi_ok = 1;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #2;
      if (pin !== 1'b0) hi_ok = 0;
    end
    check(hi_ok == 1, "R4 pass-through gated", hi_ok, 1);

    // R2 fallback from clock mode
    @(negedge clk);
    alt_en = 1'b0; goe = 1'b1; gout = 1'b1;
    @(negedge clk);
    check(pin_oe == 1'b1 && pin == 1'b1, "R2 fallback", {pin_oe, pin}, 3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule